// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This block moves outgoing frames from host memory to a transmit FIFO. Software builds a list of four-word descriptors in memory, each naming one data buffer. It sets the ownership flag of each descriptor it hands over and then raises the start control. The engine reads each descriptor through a single word-wide memory port. It streams the buffer contents out word by word and marks the first word of a frame and its last word. When the frame is done, it writes the completion status back and returns the descriptor to the host.

A frame may span several descriptors. Every descriptor except the last is returned with a zero status word. The last one receives the status word from the MAC and, when the MAC reports one, the timestamp. The next descriptor is found in one of two ways: a forward step of 16 bytes with a wrap flag that sends the engine back to the list base, or an explicit pointer for chained lists. A descriptor the host still owns, or a memory error, parks the engine in a suspended state. It leaves that state only on a poll demand while the underflow status is clear.

Top module: `txdma_engine`

## Requirements
- R1: After reset, `dmaState` is 0 (stopped), `memReq` and `txValid` are low and all three flags are clear.
- R2: When `startBit` rises while stopped, the engine loads the descriptor address from `listBase` and fetches that descriptor first. `dmaState` reads 1 while running.
- R3: If word 0 bit 31 (ownership) of a fetched descriptor is 0, the engine moves data for none of it. `dmaState` becomes 2 (suspended) and both `flagTbu` and `flagNis` are set.
- R4: Buffer words are read from consecutive addresses starting at word 2 and delivered in order. The count is the byte count in word 1 bits 12:0, rounded up to whole words. The output holds each word until `txReady`. `txSof` marks the first word of a buffer whose word 1 bit 29 (first segment) is set. `txEof` marks the last word of a buffer whose word 1 bit 30 (last segment) is set. `txEofBytes` gives the valid bytes of that word (1 to 4).
- R5: After a buffer without the last-segment flag, the engine writes 0 to that descriptor's word 0, which clears ownership, and continues the frame with the next descriptor.
- R6: After the last buffer, the engine waits for `statValid` and then writes {0, `statWord`} into word 0 of the last descriptor.
- R7: If `statTs` is 1, words 2 and 3 of the last descriptor receive `statTsLo` and `statTsHi`. If it is 0, those words are left unchanged.
- R8: `flagTi` (and with it `flagNis`) is set after the status write only when word 1 bit 31 (interrupt on completion) of the last descriptor is set.
- R9: While suspended with `startBit` high, the engine stays suspended unless `pollDemand` arrives while `underflow` is 0. It then refetches the same descriptor.
- R10: Without chaining, the next descriptor lies 16 bytes further on. If word 1 bit 25 (ring end) is set, the next descriptor is `listBase` instead.
- R11: With word 1 bit 24 (chain) set, the next descriptor address is taken from word 3.
- R12: Dropping `startBit` lets the current frame finish. The engine then stops (`dmaState` 0) before fetching the next descriptor, and it stops at once when suspended.
- R13: Each flag is cleared by a one-cycle pulse on its clear input. A set in the same cycle takes priority.
- R14: A memory access answered with `memErr` suspends the engine and sets `flagTbu` and `flagNis`. No write-back is made for that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startBit | input | 1 | Run control (level) |
| pollDemand | input | 1 | One-cycle poll request |
| underflow | input | 1 | Underflow status; blocks resume while high |
| listBase | input | ADDR_W | Byte address of the first descriptor |
| memReq | output | 1 | Memory access request, held until `memAck` |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Access complete |
| memErr | input | 1 | Access failed, valid with `memAck` |
| txValid | output | 1 | Output word valid |
| txReady | input | 1 | FIFO accepts the word |
| txData | output | 32 | Frame data word |
| txSof | output | 1 | First word of a frame |
| txEof | output | 1 | Last word of a frame |
| txEofBytes | output | 3 | Valid bytes in the last word |
| statValid | input | 1 | Completion status strobe |
| statWord | input | 31 | Completion status |
| statTs | input | 1 | Timestamp captured for this frame |
| statTsLo | input | 32 | Timestamp low word |
| statTsHi | input | 32 | Timestamp high word |
| clrTbu | input | 1 | Clear `flagTbu` |
| clrNis | input | 1 | Clear `flagNis` |
| clrTi | input | 1 | Clear `flagTi` |
| flagTbu | output | 1 | Buffer unavailable / suspended on error |
| flagNis | output | 1 | Normal interrupt summary |
| flagTi | output | 1 | Frame transmitted with interrupt request |
| dmaState | output | 2 | 0 stopped, 1 running, 2 suspended |

## Verification
The assertions take for granted that the memory answers each request with exactly one `memAck` pulse and never acks while no request is pending. They also assume `statValid` comes only after the end-of-frame word has been accepted. The stimulus follows both rules. Its memory model acks one cycle after it sees a request and then drops the ack. The status responder fires a fixed number of cycles after it observes the `txEof` handshake. Descriptors are changed only while the engine is stopped or suspended, and every buffer holds at least one byte.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  localparam int WORD_W = 32;

  // descriptor bit positions the engine decodes
  localparam int OwnBit   = 31;  // word 0
  localparam int IocBit   = 31;  // word 1
  localparam int LastBit  = 30;
  localparam int FirstBit = 29;
  localparam int WrapBit  = 25;
  localparam int ChainBit = 24;

  localparam logic [1:0] StStopped = 2'd0;
  localparam logic [1:0] StRunning = 2'd1;
  localparam logic [1:0] StSuspend = 2'd2;

  typedef enum logic [3:0] {
    S_STOP, S_POLL, S_RD0, S_RD1, S_RD2, S_RD3, S_DRD, S_DOUT,
    S_CLOSE, S_STAT, S_TS2, S_TS3, S_WST0, S_NEXT, S_SUSP
  } engState_t;

  typedef enum logic [2:0] {A_W0, A_W1, A_W2, A_W3, A_BUF} addrSel_t;
  typedef enum logic [1:0] {D_ZERO, D_STAT, D_TSLO, D_TSHI} wdSel_t;

  typedef struct packed {
    logic     loadBase;
    logic     capW1;
    logic     capW2;
    logic     capW3;
    logic     capData;
    logic     advBuf;
    logic     capStat;
    logic     setTbu;
    logic     setTi;
    logic     nextDesc;
    addrSel_t addrSel;
    wdSel_t   wdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startBit,
  input  logic       pollDemand,
  input  logic       underflow,
  input  logic       memAck,
  input  logic       memErr,
  input  logic       txReady,
  input  logic       statValid,
  input  logic       statTs,
  input  logic       rdOwn,
  input  logic       bufEmpty,
  input  logic       lastWord,
  input  logic       isLast,
  input  logic       iocSet,
  output logic       memReq,
  output logic       memWe,
  output logic       txValid,
  output logic [1:0] dmaState,
  output ctlStrobe_t ctl
);

  engState_t state, nextState;
  engState_t endOfBuf;
  logic      ackOk;

  assign ackOk    = memAck && !memErr;
  assign endOfBuf = isLast ? S_STAT : S_CLOSE;

  always_comb begin
    memReq = 1'b0;
    memWe  = 1'b0;
    unique case (state)
      S_RD0, S_RD1, S_RD2, S_RD3, S_DRD: memReq = 1'b1;
      S_CLOSE, S_TS2, S_TS3, S_WST0: begin
        memReq = 1'b1;
        memWe  = 1'b1;
      end
      default: ;
    endcase
  end

  assign txValid = (state == S_DOUT);

  always_comb begin
    unique case (state)
      S_STOP:  dmaState = StStopped;
      S_SUSP:  dmaState = StSuspend;
      default: dmaState = StRunning;
    endcase
  end

  always_comb begin
    ctl         = '0;
    ctl.addrSel = A_W0;
    ctl.wdSel   = D_ZERO;
    nextState   = state;
    unique case (state)
      S_STOP: if (startBit) begin
        ctl.loadBase = 1'b1;
        nextState    = S_POLL;
      end
      S_POLL: nextState = startBit ? S_RD0 : S_STOP;
      S_RD0: begin
        ctl.addrSel = A_W0;
        if (ackOk) begin
          if (rdOwn) nextState = S_RD1;
          else begin
            ctl.setTbu = 1'b1;
            nextState  = S_SUSP;
          end
        end
      end
      S_RD1: begin
        ctl.addrSel = A_W1;
        if (ackOk) begin
          ctl.capW1 = 1'b1;
          nextState = S_RD2;
        end
      end
      S_RD2: begin
        ctl.addrSel = A_W2;
        if (ackOk) begin
          ctl.capW2 = 1'b1;
          nextState = S_RD3;
        end
      end
      S_RD3: begin
        ctl.addrSel = A_W3;
        if (ackOk) begin
          ctl.capW3 = 1'b1;
          nextState = bufEmpty ? endOfBuf : S_DRD;
        end
      end
      S_DRD: begin
        ctl.addrSel = A_BUF;
        if (ackOk) begin
          ctl.capData = 1'b1;
          nextState   = S_DOUT;
        end
      end
      S_DOUT: if (txReady) begin
        ctl.advBuf = 1'b1;
        nextState  = lastWord ? endOfBuf : S_DRD;
      end
      S_CLOSE: begin
        ctl.addrSel = A_W0;
        ctl.wdSel   = D_ZERO;
        if (ackOk) nextState = S_NEXT;
      end
      S_STAT: if (statValid) begin
        ctl.capStat = 1'b1;
        nextState   = statTs ? S_TS2 : S_WST0;
      end
      S_TS2: begin
        ctl.addrSel = A_W2;
        ctl.wdSel   = D_TSLO;
        if (ackOk) nextState = S_TS3;
      end
      S_TS3: begin
        ctl.addrSel = A_W3;
        ctl.wdSel   = D_TSHI;
        if (ackOk) nextState = S_WST0;
      end
      S_WST0: begin
        ctl.addrSel = A_W0;
        ctl.wdSel   = D_STAT;
        if (ackOk) begin
          ctl.setTi = iocSet;
          nextState = S_NEXT;
        end
      end
      S_NEXT: begin
        ctl.nextDesc = 1'b1;
        nextState    = S_POLL;
      end
      S_SUSP: begin
        if (!startBit) nextState = S_STOP;
        else if (pollDemand && !underflow) nextState = S_POLL;
      end
      default: nextState = S_STOP;
    endcase
    // a failed access parks the engine without touching the descriptor
    if (memReq && memAck && memErr) begin
      ctl.setTbu = 1'b1;
      nextState  = S_SUSP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_STOP;
    else       state <= nextState;
  end

endmodule

// File: rtl/txdma_dpath.sv
module txdma_dpath
  import txdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BCNT_W     = 13,
  parameter int DESC_BYTES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [ADDR_W-1:0]   listBase,
  input  logic [WORD_W-1:0]   memRdata,
  input  logic [WORD_W-2:0]   statWord,
  input  logic [WORD_W-1:0]   statTsLo,
  input  logic [WORD_W-1:0]   statTsHi,
  input  logic                clrTbu,
  input  logic                clrNis,
  input  logic                clrTi,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memWdata,
  output logic [WORD_W-1:0]   txData,
  output logic                txSof,
  output logic                txEof,
  output logic [2:0]          txEofBytes,
  output logic                flagTbu,
  output logic                flagNis,
  output logic                flagTi,
  output logic                rdOwn,
  output logic                bufEmpty,
  output logic                lastWord,
  output logic                isLast,
  output logic                iocSet
);

  localparam int WCNT_W = BCNT_W - 1;
  localparam int WORD_BYTES = WORD_W / 8;

  logic [ADDR_W-1:0] descAddr, bufAddr, nextPtr, nextDescAddr;
  logic [WCNT_W-1:0] wordsLeft;
  logic [BCNT_W:0]   roundUp;
  logic              firstWord;
  logic              segFirst, segWrap, segChain;
  logic [1:0]        tailBytes;
  logic [WORD_W-2:0] statReg;
  logic [WORD_W-1:0] tsLoReg, tsHiReg;
  logic [ADDR_W-1:0] wordOfs [4];

  assign rdOwn    = memRdata[OwnBit];
  assign bufEmpty = (wordsLeft == '0);
  assign lastWord = (wordsLeft == WCNT_W'(1));
  assign roundUp  = {1'b0, memRdata[BCNT_W-1:0]} + (BCNT_W+1)'(3);

  // address of each descriptor word
  for (genvar g = 0; g < 4; g++) begin : g_ofs
    assign wordOfs[g] = descAddr + ADDR_W'(g * WORD_BYTES);
  end

  always_comb begin
    unique case (ctl.addrSel)
      A_W0:    memAddr = wordOfs[0];
      A_W1:    memAddr = wordOfs[1];
      A_W2:    memAddr = wordOfs[2];
      A_W3:    memAddr = wordOfs[3];
      default: memAddr = bufAddr;
    endcase
  end

  always_comb begin
    unique case (ctl.wdSel)
      D_STAT:  memWdata = {1'b0, statReg};
      D_TSLO:  memWdata = tsLoReg;
      D_TSHI:  memWdata = tsHiReg;
      default: memWdata = '0;
    endcase
  end

  always_comb begin
    if (segChain)     nextDescAddr = nextPtr;
    else if (segWrap) nextDescAddr = listBase;
    else              nextDescAddr = descAddr + ADDR_W'(DESC_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr <= '0;
      bufAddr  <= '0;
      nextPtr  <= '0;
      wordsLeft <= '0;
      firstWord <= 1'b0;
      segFirst <= 1'b0;
      isLast   <= 1'b0;
      iocSet   <= 1'b0;
      segWrap  <= 1'b0;
      segChain <= 1'b0;
      tailBytes <= '0;
    end else begin
      if (ctl.loadBase) descAddr <= listBase;
      else if (ctl.nextDesc) descAddr <= nextDescAddr;
      if (ctl.capW1) begin
        iocSet    <= memRdata[IocBit];
        isLast    <= memRdata[LastBit];
        segFirst  <= memRdata[FirstBit];
        segWrap   <= memRdata[WrapBit];
        segChain  <= memRdata[ChainBit];
        tailBytes <= memRdata[1:0];
        wordsLeft <= roundUp[BCNT_W:2];
        firstWord <= 1'b1;
      end
      if (ctl.capW2) bufAddr <= memRdata[ADDR_W-1:0];
      if (ctl.capW3) nextPtr <= memRdata[ADDR_W-1:0];
      if (ctl.advBuf) begin
        bufAddr   <= bufAddr + ADDR_W'(WORD_BYTES);
        wordsLeft <= wordsLeft - WCNT_W'(1);
        firstWord <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData     <= '0;
      txSof      <= 1'b0;
      txEof      <= 1'b0;
      txEofBytes <= '0;
    end else if (ctl.capData) begin
      txData <= memRdata;
      txSof  <= segFirst && firstWord;
      txEof  <= isLast && lastWord;
      if (isLast && lastWord)
        txEofBytes <= (tailBytes == 2'd0) ? 3'd4 : {1'b0, tailBytes};
      else
        txEofBytes <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
      tsLoReg <= '0;
      tsHiReg <= '0;
    end else if (ctl.capStat) begin
      statReg <= statWord;
      tsLoReg <= statTsLo;
      tsHiReg <= statTsHi;
    end
  end

  // clear by pulse, a simultaneous set wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagTbu <= 1'b0;
      flagNis <= 1'b0;
      flagTi  <= 1'b0;
    end else begin
      flagTbu <= (flagTbu && !clrTbu) || ctl.setTbu;
      flagTi  <= (flagTi && !clrTi) || ctl.setTi;
      flagNis <= (flagNis && !clrNis) || ctl.setTbu || ctl.setTi;
    end
  end

endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
  import txdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BCNT_W     = 13,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startBit,
  input  logic              pollDemand,
  input  logic              underflow,
  input  logic [ADDR_W-1:0] listBase,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  input  logic              memErr,
  output logic              txValid,
  input  logic              txReady,
  output logic [31:0]       txData,
  output logic              txSof,
  output logic              txEof,
  output logic [2:0]        txEofBytes,
  input  logic              statValid,
  input  logic [30:0]       statWord,
  input  logic              statTs,
  input  logic [31:0]       statTsLo,
  input  logic [31:0]       statTsHi,
  input  logic              clrTbu,
  input  logic              clrNis,
  input  logic              clrTi,
  output logic              flagTbu,
  output logic              flagNis,
  output logic              flagTi,
  output logic [1:0]        dmaState
);

  ctlStrobe_t ctl;
  logic rdOwn, bufEmpty, lastWord, isLast, iocSet;

  txdma_ctrl u_ctrl (
    .clk, .rstN, .startBit, .pollDemand, .underflow,
    .memAck, .memErr, .txReady, .statValid, .statTs,
    .rdOwn, .bufEmpty, .lastWord, .isLast, .iocSet,
    .memReq, .memWe, .txValid, .dmaState, .ctl
  );

  txdma_dpath #(
    .ADDR_W(ADDR_W), .BCNT_W(BCNT_W), .DESC_BYTES(DESC_BYTES)
  ) u_dpath (
    .clk, .rstN, .ctl, .listBase, .memRdata, .statWord, .statTsLo, .statTsHi,
    .clrTbu, .clrNis, .clrTi, .memAddr, .memWdata, .txData, .txSof, .txEof,
    .txEofBytes, .flagTbu, .flagNis, .flagTi, .rdOwn, .bufEmpty, .lastWord,
    .isLast, .iocSet
  );

endmodule

// File: rtl/txdma_chk.sv
module txdma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startBit,
  input logic              pollDemand,
  input logic              underflow,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              txValid,
  input logic              txReady,
  input logic [31:0]       txData,
  input logic              txSof,
  input logic              txEof,
  input logic              flagTbu,
  input logic              flagNis,
  input logic              flagTi,
  input logic [1:0]        dmaState
);

  // R4: a pending memory request keeps its address and direction
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R4: an output word waits unchanged for the FIFO
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txSof) && $stable(txEof));

  // R3: buffer-unavailable always raises the summary flag
  p_tbu_nis_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagTbu) |-> flagNis);

  // R8: transmit interrupt always raises the summary flag
  p_ti_nis_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagTi) |-> flagNis);

  // R9: suspended engine ignores everything but a valid poll demand
  p_susp_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dmaState == 2'd2) && startBit && !(pollDemand && !underflow) |=> dmaState == 2'd2);

  // R12: a stopped engine makes no memory access and no output
  p_stop_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (dmaState == 2'd0) |-> !memReq && !txValid);

  // R3: a suspended engine makes no memory access
  p_susp_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dmaState == 2'd2) |-> !memReq && !txValid);

endmodule

bind txdma_engine txdma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .startBit(startBit), .pollDemand(pollDemand),
  .underflow(underflow), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memAck(memAck), .txValid(txValid), .txReady(txReady), .txData(txData),
  .txSof(txSof), .txEof(txEof), .flagTbu(flagTbu), .flagNis(flagNis),
  .flagTi(flagTi), .dmaState(dmaState)
);

// File: tb/txdma_engine_tb.sv
module txdma_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startBit = 1'b0, pollDemand = 1'b0, underflow = 1'b0;
  logic [31:0] listBase = '0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0, memErr = 1'b0;
  logic        txValid, txSof, txEof;
  logic        txReady = 1'b0;
  logic [31:0] txData;
  logic [2:0]  txEofBytes;
  logic        statValid = 1'b0, statTs = 1'b0;
  logic [30:0] statWord = '0;
  logic [31:0] statTsLo = '0, statTsHi = '0;
  logic        clrTbu = 1'b0, clrNis = 1'b0, clrTi = 1'b0;
  logic        flagTbu, flagNis, flagTi;
  logic [1:0]  dmaState;

  always #10 clk = ~clk;  // 50 MHz

  txdma_engine u_dut (.*);

  // descriptor word 1 fields
  localparam logic [31:0] IOC = 32'h8000_0000, LS = 32'h4000_0000, FS = 32'h2000_0000;
  localparam logic [31:0] RER = 32'h0200_0000, CHN = 32'h0100_0000, OWN = 32'h8000_0000;

  int checks = 0, fails = 0, cyc = 0, statCnt = 0;
  bit done = 1'b0;
  logic [31:0] mem [0:255];
  logic        hwEn = 1'b0;
  logic [31:0] hwAddr = '0, hwData = '0;
  logic [30:0] curStat = '0;
  logic        curTs = 1'b0;
  logic [31:0] curTsLo = '0, curTsHi = '0;
  logic [36:0] expQ [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: ack one cycle after a request, error above 1 KiB
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      memAck <= 1'b0;
      memErr <= 1'b0;
    end else begin
      memAck <= 1'b0;
      memErr <= 1'b0;
      if (hwEn) mem[hwAddr[9:2]] <= hwData;
      if (memReq && !memAck) begin
        memAck <= 1'b1;
        if (memAddr[31:10] != '0) memErr <= 1'b1;
        else begin
          if (memWe) mem[memAddr[9:2]] <= memWdata;
          memRdata <= mem[memAddr[9:2]];
        end
      end
    end
  end

  // monitor: FIFO backpressure, status responder, scoreboard compare
  always @(negedge clk) begin
    cyc++;
    txReady = (cyc % 3) != 1;
    statValid = 1'b0;
    if (statCnt > 0) begin
      statCnt--;
      if (statCnt == 0) begin
        statValid = 1'b1;
        statWord = curStat;
        statTs = curTs;
        statTsLo = curTsLo;
        statTsHi = curTsHi;
      end
    end
    if (rstN && txValid && txReady) begin
      if (expQ.size() == 0) check(1'b0, "R4 unexpected word", txData, 32'h0);
      else begin
        logic [36:0] e;
        e = expQ.pop_front();
        check({txData, txSof, txEof, txEofBytes} == e, "R4 stream word",
              {txData[27:0], txSof, txEof, txEofBytes[1:0]}, {e[32:5], e[4], e[3], e[1:0]});
      end
      if (txEof) statCnt = 3;
    end
  end

  task automatic hw(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); hwEn = 1'b1; hwAddr = a; hwData = d;
    @(negedge clk); hwEn = 1'b0;
  endtask

  task automatic setDesc(input logic [31:0] a, input logic [31:0] w0, w1, w2, w3);
    hw(a, w0); hw(a + 4, w1); hw(a + 8, w2); hw(a + 12, w3);
  endtask

  task automatic fillBuf(input logic [31:0] a, input int nw, input logic [31:0] seed);
    for (int i = 0; i < nw; i++) hw(a + 4 * i, seed + i);
  endtask

  task automatic expectBuf(input logic [31:0] a, input int nb, input bit fs, input bit ls);
    int nw = (nb + 3) / 4;
    for (int i = 0; i < nw; i++) begin
      bit eof = ls && (i == nw - 1);
      logic [2:0] eb = eof ? ((nb % 4 == 0) ? 3'd4 : 3'(nb % 4)) : 3'd0;
      expQ.push_back({mem[(a >> 2) + i], fs && (i == 0), eof, eb});
    end
  endtask

  task automatic waitState(input logic [1:0] st);
    int n = 0;
    while (dmaState != st && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic pulsePoll();
    @(negedge clk); pollDemand = 1'b1;
    @(negedge clk); pollDemand = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clearFlags();
    @(negedge clk); clrTbu = 1'b1; clrNis = 1'b1; clrTi = 1'b1;
    @(negedge clk); clrTbu = 1'b0; clrNis = 1'b0; clrTi = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dmaState == 2'd0, "R1 state", 32'(dmaState), 0);
    check(!memReq && !txValid, "R1 idle ports", {memReq, txValid}, 0);
    check({flagTbu, flagNis, flagTi} == 3'b0, "R1 flags", {flagTbu, flagNis, flagTi}, 0);

    // single-buffer frame with timestamp and interrupt request
    fillBuf(32'h100, 3, 32'hA000_0000);
    setDesc(32'h000, OWN, IOC | LS | FS | 32'd10, 32'h100, 32'h0);
    setDesc(32'h010, 32'h0, 32'h0, 32'h0, 32'h0);
    expectBuf(32'h100, 10, 1, 1);
    curStat = 31'h1234; curTs = 1'b1; curTsLo = 32'hAAAA_5555; curTsHi = 32'h0000_BEEF;
    listBase = 32'h0;
    @(negedge clk); startBit = 1'b1;
    repeat (3) @(negedge clk);
    check(dmaState == 2'd1, "R2 running", 32'(dmaState), 1);
    waitState(2'd2);
    check(expQ.size() == 0, "R2 frame from list base delivered", expQ.size(), 0);
    check(mem[0] == 32'h0000_1234, "R6 status write-back", mem[0], 32'h1234);
    check(mem[2] == 32'hAAAA_5555 && mem[3] == 32'h0000_BEEF, "R7 timestamp written", mem[2], 32'hAAAA_5555);
    check(flagTi, "R8 interrupt on completion", 32'(flagTi), 1);
    check(flagTbu && flagNis && dmaState == 2'd2, "R3 host-owned suspends", {flagTbu, flagNis, dmaState}, 4'b1110);

    // R13 clear by pulse
    clearFlags();
    check({flagTbu, flagNis, flagTi} == 3'b0, "R13 flags cleared", {flagTbu, flagNis, flagTi}, 0);

    // two-buffer frame ending in ring wrap, no timestamp, no interrupt
    fillBuf(32'h140, 2, 32'hB000_0000);
    fillBuf(32'h180, 1, 32'hC000_0000);
    setDesc(32'h010, OWN, FS | 32'd8, 32'h140, 32'h77);
    setDesc(32'h020, OWN, LS | RER | 32'd4, 32'h180, 32'h1234_5678);
    setDesc(32'h030, OWN, FS | LS | 32'd4, 32'h1C0, 32'h0);
    curStat = 31'h00C0_FFEE; curTs = 1'b0;
    underflow = 1'b1;
    pulsePoll();
    repeat (20) @(negedge clk);
    check(dmaState == 2'd2, "R9 no resume under underflow", 32'(dmaState), 2);
    underflow = 1'b0;
    expectBuf(32'h140, 8, 1, 0);
    expectBuf(32'h180, 4, 0, 1);
    pulsePoll();
    waitState(2'd2);
    check(expQ.size() == 0, "R9 resumed and R5 frame delivered", expQ.size(), 0);
    check(mem[4] == 32'h0, "R5 intermediate descriptor closed", mem[4], 0);
    check(mem[8] == 32'h00C0_FFEE, "R6 last descriptor status", mem[8], 32'h00C0_FFEE);
    check(mem[10] == 32'h180 && mem[11] == 32'h1234_5678, "R7 words untouched", mem[11], 32'h1234_5678);
    check(!flagTi, "R8 no interrupt without request", 32'(flagTi), 0);
    check(flagTbu && mem[12] == OWN, "R10 wrap to base skips next slot", mem[12], OWN);

    // chained list
    clearFlags();
    fillBuf(32'h1C0, 2, 32'hD000_0000);
    fillBuf(32'h240, 2, 32'hE000_0000);
    setDesc(32'h000, OWN, IOC | FS | LS | CHN | 32'd4, 32'h1C0, 32'h200);
    setDesc(32'h010, OWN, FS | LS | 32'd4, 32'h1C4, 32'h0);
    setDesc(32'h200, OWN, FS | LS | CHN | 32'd6, 32'h240, 32'h210);
    setDesc(32'h210, 32'h0, 32'h0, 32'h0, 32'h0);
    curStat = 31'h55;
    expectBuf(32'h1C0, 4, 1, 1);
    expectBuf(32'h240, 6, 1, 1);
    pulsePoll();
    waitState(2'd2);
    check(expQ.size() == 0, "R11 chained frames delivered", expQ.size(), 0);
    check(mem[128] == 32'h55, "R11 pointer target written back", mem[128], 32'h55);
    check(mem[4] == OWN, "R11 sequential slot untouched", mem[4], OWN);
    check(flagTi, "R8 interrupt from first chained frame", 32'(flagTi), 1);

    // memory error on buffer read
    clearFlags();
    setDesc(32'h210, OWN, FS | LS | 32'd4, 32'h800, 32'h0);
    pulsePoll();
    waitState(2'd2);
    check(flagTbu && flagNis && dmaState == 2'd2, "R14 error suspends", {flagTbu, flagNis, dmaState}, 4'b1110);
    check(mem[132] == OWN, "R14 no write-back", mem[132], OWN);

    // stop from suspend, restart at a new base, stop mid-frame
    @(negedge clk); startBit = 1'b0;
    repeat (3) @(negedge clk);
    check(dmaState == 2'd0, "R12 stop from suspend", 32'(dmaState), 0);
    clearFlags();
    fillBuf(32'h380, 1, 32'hF000_0000);
    setDesc(32'h300, OWN, FS | LS | RER | 32'd4, 32'h380, 32'h0);
    curStat = 31'h77;
    expectBuf(32'h380, 4, 1, 1);
    listBase = 32'h300;
    @(negedge clk); startBit = 1'b1;
    begin
      int n = 0;
      while (!txValid && n < 2000) begin @(negedge clk); n++; end
    end
    startBit = 1'b0;
    repeat (3) @(negedge clk);
    waitState(2'd0);
    check(expQ.size() == 0, "R12 frame finished before stop", expQ.size(), 0);
    check(dmaState == 2'd0 && !flagTbu, "R12 stopped without suspend", {flagTbu, dmaState}, 0);
    check(mem[192] == 32'h77, "R2 restart at new base", mem[192], 32'h77);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule